// File: doc/BRIEF.md
# Inbound Hub Memory Decoder

This block sits behind the downstream hub port and judges every request that arrives from it. A memory request below 4 GB is either accepted and passed to DRAM untouched, or found invalid and steered to DRAM address 0 with a host snoop. Invalid requests are not dropped, so the DRAM path still sees a transaction, but it can do no harm: reads return all-ones data and writes carry no byte enables. Memory requests above 4 GB and every I/O request are refused outright, and never reach DRAM.

The accepted regions are configured by static inputs: a top-of-memory limit, an SMM window that is carved out of DRAM, a graphics aperture given by a base and a size code, and the fixed VGA window, which only accepts writes. The block samples a request on the clock edge where `req_valid` is high. On the next cycle it presents the registered decision: whether DRAM is issued, the DRAM address and byte enables, the snoop flag, the completion code, and the all-ones read-data override.

Top module: `hub_mem_decoder`

## Requirements
- R1: A request sampled with `req_valid` high yields `rsp_valid` high on the following cycle and on no other cycle. After reset `rsp_valid`, `rsp_dram_en`, `rsp_snoop`, `rsp_rd_ones`, `rsp_cpl`, `rsp_addr` and `rsp_be` are all zero.
- R2: An I/O request (`req_is_io`=1) gets completion code 2'b01 (master abort). `rsp_dram_en`, `rsp_snoop` and `rsp_rd_ones` are 0, and `rsp_addr` and `rsp_be` are 0.
- R3: A memory read with any address bit at position 32 or higher set gets code 2'b01. DRAM is not issued, there is no snoop, and the address and byte enables are 0.
- R4: A memory write with any address bit at position 32 or higher set is discarded. It gets code 2'b11 (no completion), whatever `req_needs_cpl` is. DRAM is not issued, and the address and byte enables are 0.
- R5: A memory request with an address below `cfg_tom` that hits no other rule is accepted. `rsp_dram_en`=1, `rsp_addr` equals the low 32 address bits, `rsp_be` equals `req_be`, and there is no snoop and no override. A read gets code 2'b00. A write gets 2'b00 when `req_needs_cpl`=1, otherwise 2'b11.
- R6: A request in the SMM window (`cfg_smm_base` ≤ address < `cfg_smm_limit`) is invalid even when it lies below `cfg_tom`.
- R7: The aperture is accepted as in R5, even above `cfg_tom`. Its size is 4 MB << `cfg_ap_size` for codes 0 to 6, and the aperture matches when the address and `cfg_ap_base` agree in every bit at or above log2(size). Code 7 disables the aperture.
- R8: Writes to 0xA0000–0xBFFFF (inclusive) are accepted. Reads of that range are invalid.
- R9: An invalid read is issued to DRAM at address 0 with `rsp_snoop`=1, `rsp_rd_ones`=1, code 2'b01, and `rsp_be` equal to `req_be`.
- R10: An invalid write is issued to DRAM at address 0 with `rsp_snoop`=1 and `rsp_be` all zero. It gets code 2'b01 when `req_needs_cpl`=1, otherwise 2'b11.
- R11: Back-to-back requests on consecutive cycles are each decoded with their own configuration and ordering.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_addr | input | ADDR_W (40) | Request address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_is_io | input | 1 | 1 = I/O request, 0 = memory |
| req_needs_cpl | input | 1 | Write asks for a completion |
| req_be | input | BE_W (4) | Request byte enables |
| cfg_tom | input | 32 | Top of DRAM, exclusive |
| cfg_smm_base | input | 32 | SMM window start, inclusive |
| cfg_smm_limit | input | 32 | SMM window end, exclusive |
| cfg_ap_base | input | 32 | Aperture base |
| cfg_ap_size | input | AP_SEL_W (3) | Aperture size code, 7 = off |
| rsp_valid | output | 1 | Decision valid |
| rsp_dram_en | output | 1 | Issue to DRAM |
| rsp_addr | output | 32 | DRAM address |
| rsp_be | output | BE_W (4) | DRAM byte enables |
| rsp_snoop | output | 1 | Snoop the host bus |
| rsp_cpl | output | 2 | 00 ok, 01 master abort, 11 none |
| rsp_rd_ones | output | 1 | Replace read data with all ones |

## Verification
The checker watches several rules on every cycle. It checks the one-cycle strobe timing and the outcomes for I/O and for addresses above 4 GB, which depend only on the request. It also checks that every snooped response targets DRAM address 0, and that the all-ones override always comes with a master abort. Which region a request falls in depends on the configuration windows, so the bench scenarios have to show that part. These scenarios include the SMM and VGA edges, the aperture size codes and the disable code, the top-of-memory limit, and write completions with and without a completion request.

// File: rtl/hubdec_pkg.sv
package hubdec_pkg;

   typedef enum logic [1:0] {
      CPL_OK   = 2'b00,
      CPL_MA   = 2'b01,
      CPL_NONE = 2'b11
   } cpl_e;

   typedef struct packed {
      logic dram_en;
      logic snoop;
      logic rd_ones;
      logic keep_addr;
      logic keep_be;
      cpl_e cpl;
   } action_t;

endpackage

// File: rtl/hubdec_window.sv
module hubdec_window #(
   parameter int W       = 32,
   parameter bit INCL_HI = 1'b0
) (
   input  logic [W-1:0] addr,
   input  logic [W-1:0] lo,
   input  logic [W-1:0] hi,
   output logic         hit
);
   logic above_lo;
   logic below_hi;

   assign above_lo = (addr >= lo);

   generate
      if (INCL_HI) begin : g_incl
         assign below_hi = (addr <= hi);
      end else begin : g_excl
         assign below_hi = (addr < hi);
      end
   endgenerate

   assign hit = above_lo & below_hi;
endmodule

// File: rtl/hubdec_aperture.sv
module hubdec_aperture #(
   parameter int AW       = 32,
   parameter int MIN_LOG2 = 22,
   parameter int N_SIZES  = 7,
   parameter int SEL_W    = 3
) (
   input  logic [AW-1:0]    addr,
   input  logic [AW-1:0]    base,
   input  logic [SEL_W-1:0] size_sel,
   output logic             hit
);
   localparam int MAX_LOG2 = MIN_LOG2 + N_SIZES - 1;

   generate
      if (MAX_LOG2 >= AW) begin : g_bad_span
         $error("aperture sizes exceed address width");
      end
      if (N_SIZES > (1 << SEL_W)) begin : g_bad_sel
         $error("size code too narrow for size count");
      end
   endgenerate

   logic [AW-1:0] mask_tab [N_SIZES];

   generate
      for (genvar g = 0; g < N_SIZES; g++) begin : g_mask
         assign mask_tab[g] = ~((AW'(1) << (MIN_LOG2 + g)) - AW'(1));
      end
   endgenerate

   logic [AW-1:0] sel_mask;
   logic          enabled;

   always_comb begin
      sel_mask = '0;
      enabled  = 1'b0;
      for (int i = 0; i < N_SIZES; i++) begin
         if (size_sel == SEL_W'(i)) begin
            sel_mask = mask_tab[i];
            enabled  = 1'b1;
         end
      end
   end

   assign hit = enabled && (((addr ^ base) & sel_mask) == '0);
endmodule

// File: rtl/hubdec_classify.sv
module hubdec_classify
   import hubdec_pkg::*;
(
   input  logic    is_io,
   input  logic    high_addr,
   input  logic    is_write,
   input  logic    needs_cpl,
   input  logic    smm_hit,
   input  logic    ap_hit,
   input  logic    vga_hit,
   input  logic    dram_hit,
   output action_t act
);
   logic accept;

   assign accept = !smm_hit && (ap_hit || (vga_hit ? is_write : dram_hit));

   always_comb begin
      act = '{dram_en: 1'b0, snoop: 1'b0, rd_ones: 1'b0,
              keep_addr: 1'b0, keep_be: 1'b0, cpl: CPL_MA};
      if (is_io) begin
         act.cpl = CPL_MA;
      end else if (high_addr) begin
         act.cpl = is_write ? CPL_NONE : CPL_MA;
      end else if (accept) begin
         act.dram_en   = 1'b1;
         act.keep_addr = 1'b1;
         act.keep_be   = 1'b1;
         act.cpl       = (is_write && !needs_cpl) ? CPL_NONE : CPL_OK;
      end else begin
         act.dram_en = 1'b1;
         act.snoop   = 1'b1;
         act.rd_ones = !is_write;
         act.keep_be = !is_write;
         act.cpl     = (is_write && !needs_cpl) ? CPL_NONE : CPL_MA;
      end
   end
endmodule

// File: rtl/hub_mem_decoder.sv
module hub_mem_decoder
   import hubdec_pkg::*;
#(
   parameter int          ADDR_W      = 40,
   parameter int          BE_W        = 4,
   parameter int          AP_MIN_LOG2 = 22,
   parameter int          AP_SIZES    = 7,
   parameter int          AP_SEL_W    = 3,
   parameter bit          SMM_EN      = 1'b1,
   parameter logic [31:0] VGA_LO      = 32'h000A_0000,
   parameter logic [31:0] VGA_HI      = 32'h000B_FFFF
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   input  logic [ADDR_W-1:0]   req_addr,
   input  logic                req_write,
   input  logic                req_is_io,
   input  logic                req_needs_cpl,
   input  logic [BE_W-1:0]     req_be,
   input  logic [31:0]         cfg_tom,
   input  logic [31:0]         cfg_smm_base,
   input  logic [31:0]         cfg_smm_limit,
   input  logic [31:0]         cfg_ap_base,
   input  logic [AP_SEL_W-1:0] cfg_ap_size,
   output logic                rsp_valid,
   output logic                rsp_dram_en,
   output logic [31:0]         rsp_addr,
   output logic [BE_W-1:0]     rsp_be,
   output logic                rsp_snoop,
   output logic [1:0]          rsp_cpl,
   output logic                rsp_rd_ones
);
   localparam int LOW_W = 32;

   generate
      if (ADDR_W <= LOW_W) begin : g_bad_addr
         $error("request address must be wider than 32 bits");
      end
      if (BE_W < 1) begin : g_bad_be
         $error("byte enable width must be positive");
      end
   endgenerate

   logic [LOW_W-1:0] low_addr;
   logic             high_addr;

   assign low_addr  = req_addr[LOW_W-1:0];
   assign high_addr = |req_addr[ADDR_W-1:LOW_W];

   logic dram_hit;
   logic vga_hit;
   logic smm_hit;
   logic ap_hit;

   hubdec_window #(.W(LOW_W), .INCL_HI(1'b0)) u_dram_win (
      .addr (low_addr),
      .lo   ('0),
      .hi   (cfg_tom),
      .hit  (dram_hit)
   );

   hubdec_window #(.W(LOW_W), .INCL_HI(1'b1)) u_vga_win (
      .addr (low_addr),
      .lo   (VGA_LO),
      .hi   (VGA_HI),
      .hit  (vga_hit)
   );

   generate
      if (SMM_EN) begin : g_smm
         hubdec_window #(.W(LOW_W), .INCL_HI(1'b0)) u_smm_win (
            .addr (low_addr),
            .lo   (cfg_smm_base),
            .hi   (cfg_smm_limit),
            .hit  (smm_hit)
         );
      end else begin : g_no_smm
         assign smm_hit = 1'b0;
      end
   endgenerate

   hubdec_aperture #(
      .AW       (LOW_W),
      .MIN_LOG2 (AP_MIN_LOG2),
      .N_SIZES  (AP_SIZES),
      .SEL_W    (AP_SEL_W)
   ) u_ap (
      .addr     (low_addr),
      .base     (cfg_ap_base),
      .size_sel (cfg_ap_size),
      .hit      (ap_hit)
   );

   action_t act;

   hubdec_classify u_cls (
      .is_io     (req_is_io),
      .high_addr (high_addr),
      .is_write  (req_write),
      .needs_cpl (req_needs_cpl),
      .smm_hit   (smm_hit),
      .ap_hit    (ap_hit),
      .vga_hit   (vga_hit),
      .dram_hit  (dram_hit),
      .act       (act)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid   <= 1'b0;
         rsp_dram_en <= 1'b0;
         rsp_addr    <= '0;
         rsp_be      <= '0;
         rsp_snoop   <= 1'b0;
         rsp_cpl     <= 2'b00;
         rsp_rd_ones <= 1'b0;
      end else begin
         rsp_valid <= req_valid;
         if (req_valid) begin
            rsp_dram_en <= act.dram_en;
            rsp_addr    <= act.keep_addr ? low_addr : '0;
            rsp_be      <= act.keep_be ? req_be : '0;
            rsp_snoop   <= act.snoop;
            rsp_cpl     <= act.cpl;
            rsp_rd_ones <= act.rd_ones;
         end
      end
   end
endmodule

// File: rtl/hubdec_checker.sv
module hubdec_checker #(
   parameter int ADDR_W = 40,
   parameter int BE_W   = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic [ADDR_W-1:0] req_addr,
   input logic              req_write,
   input logic              req_is_io,
   input logic              rsp_valid,
   input logic              rsp_dram_en,
   input logic [31:0]       rsp_addr,
   input logic [BE_W-1:0]   rsp_be,
   input logic              rsp_snoop,
   input logic [1:0]        rsp_cpl,
   input logic              rsp_rd_ones
);
   logic hi;
   assign hi = |req_addr[ADDR_W-1:32];

   a_r1_strobe_follows: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);

   a_r1_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);

   a_r2_io_abort: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_is_io) |=>
         (rsp_cpl == 2'b01 && !rsp_dram_en && !rsp_snoop && rsp_be == '0));

   a_r3_high_read_abort: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_is_io && !req_write && hi) |=>
         (rsp_cpl == 2'b01 && !rsp_dram_en && !rsp_snoop));

   a_r4_high_write_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_is_io && req_write && hi) |=>
         (rsp_cpl == 2'b11 && !rsp_dram_en && rsp_be == '0));

   a_r9_ones_with_abort: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_rd_ones) |-> (rsp_cpl == 2'b01 && rsp_snoop));

   a_r10_snoop_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_snoop) |-> (rsp_dram_en && rsp_addr == 32'h0));
endmodule

bind hub_mem_decoder hubdec_checker #(.ADDR_W(ADDR_W), .BE_W(BE_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .req_valid   (req_valid),
   .req_addr    (req_addr),
   .req_write   (req_write),
   .req_is_io   (req_is_io),
   .rsp_valid   (rsp_valid),
   .rsp_dram_en (rsp_dram_en),
   .rsp_addr    (rsp_addr),
   .rsp_be      (rsp_be),
   .rsp_snoop   (rsp_snoop),
   .rsp_cpl     (rsp_cpl),
   .rsp_rd_ones (rsp_rd_ones)
);

// File: tb/tb_hub_mem_decoder.sv
module tb_hub_mem_decoder;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        req_valid;
   logic [39:0] req_addr;
   logic        req_write;
   logic        req_is_io;
   logic        req_needs_cpl;
   logic [3:0]  req_be;
   logic [31:0] cfg_tom, cfg_smm_base, cfg_smm_limit, cfg_ap_base;
   logic [2:0]  cfg_ap_size;
   logic        rsp_valid, rsp_dram_en, rsp_snoop, rsp_rd_ones;
   logic [31:0] rsp_addr;
   logic [3:0]  rsp_be;
   logic [1:0]  rsp_cpl;

   always #10 clk = ~clk;

   hub_mem_decoder dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
      .req_write(req_write), .req_is_io(req_is_io), .req_needs_cpl(req_needs_cpl),
      .req_be(req_be), .cfg_tom(cfg_tom), .cfg_smm_base(cfg_smm_base),
      .cfg_smm_limit(cfg_smm_limit), .cfg_ap_base(cfg_ap_base),
      .cfg_ap_size(cfg_ap_size), .rsp_valid(rsp_valid), .rsp_dram_en(rsp_dram_en),
      .rsp_addr(rsp_addr), .rsp_be(rsp_be), .rsp_snoop(rsp_snoop),
      .rsp_cpl(rsp_cpl), .rsp_rd_ones(rsp_rd_ones)
   );

   typedef struct packed {
      logic        dram_en;
      logic [31:0] addr;
      logic [3:0]  be;
      logic        snoop;
      logic [1:0]  cpl;
      logic        ones;
      int          due;
   } exp_t;

   exp_t  exp_q[$];
   string tag_q[$];
   int    tests = 0;
   int    fails = 0;
   int    cyc = 0;
   bit    done = 1'b0;

   always @(posedge clk) cyc <= cyc + 1;

   function automatic exp_t model(logic [39:0] a40, logic wr, logic io, logic nc,
                                  logic [3:0] be);
      exp_t e;
      logic [31:0] a;
      logic [31:0] msk;
      logic ap, smm, vga, acc;
      e = '0;
      a = a40[31:0];
      if (io) begin
         e.cpl = 2'b01;
      end else if (a40[39:32] != 0) begin
         e.cpl = wr ? 2'b11 : 2'b01;
      end else begin
         msk = ~((32'h1 << (22 + cfg_ap_size)) - 32'h1);
         ap  = (cfg_ap_size != 3'd7) && (((a ^ cfg_ap_base) & msk) == 0);
         smm = (a >= cfg_smm_base) && (a < cfg_smm_limit);
         vga = (a >= 32'h000A_0000) && (a <= 32'h000B_FFFF);
         acc = !smm && (ap || (vga ? wr : (a < cfg_tom)));
         e.dram_en = 1'b1;
         if (acc) begin
            e.addr = a;
            e.be   = be;
            e.cpl  = (wr && !nc) ? 2'b11 : 2'b00;
         end else begin
            e.snoop = 1'b1;
            e.ones  = !wr;
            e.be    = wr ? 4'h0 : be;
            e.cpl   = (wr && !nc) ? 2'b11 : 2'b01;
         end
      end
      return e;
   endfunction

   task automatic send(logic [39:0] a, logic wr, logic io, logic nc, logic [3:0] be,
                       string tag);
      exp_t e;
      @(negedge clk);
      req_valid     = 1'b1;
      req_addr      = a;
      req_write     = wr;
      req_is_io     = io;
      req_needs_cpl = nc;
      req_be        = be;
      e     = model(a, wr, io, nc, be);
      e.due = cyc + 1;
      exp_q.push_back(e);
      tag_q.push_back(tag);
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         req_valid = 1'b0;
      end
   endtask

   // Monitor: pops scoreboard entries as responses appear
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (rsp_valid) begin
            tests++;
            if (exp_q.size() == 0) begin
               fails++;
               $display("FAIL R1 unexpected rsp_valid: actual 1 expected 0");
            end else begin
               exp_t  e;
               string t;
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               if (e.due != cyc || rsp_dram_en != e.dram_en || rsp_addr != e.addr ||
                   rsp_be != e.be || rsp_snoop != e.snoop || rsp_cpl != e.cpl ||
                   rsp_rd_ones != e.ones) begin
                  fails++;
                  $display("FAIL %s: actual cyc=%0d dram=%b addr=%h be=%h snp=%b cpl=%b ones=%b expected cyc=%0d dram=%b addr=%h be=%h snp=%b cpl=%b ones=%b",
                           t, cyc, rsp_dram_en, rsp_addr, rsp_be, rsp_snoop, rsp_cpl,
                           rsp_rd_ones, e.due, e.dram_en, e.addr, e.be, e.snoop,
                           e.cpl, e.ones);
               end
            end
         end else if (exp_q.size() != 0 && exp_q[0].due <= cyc) begin
            tests++;
            fails++;
            void'(exp_q.pop_front());
            void'(tag_q.pop_front());
            $display("FAIL R1 missing response: actual rsp_valid 0 expected 1");
         end
      end
   end

   // Watchdog
   always @(posedge clk) begin
      if (cyc > 20000 && !done) begin
         done = 1'b1;
         tests++;
         fails++;
         $display("FAIL watchdog: actual cycle %0d expected finish before 20000", cyc);
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0;
      req_valid = 1'b0; req_addr = '0; req_write = 1'b0; req_is_io = 1'b0;
      req_needs_cpl = 1'b0; req_be = 4'h0;
      cfg_tom       = 32'h1000_0000;
      cfg_smm_base  = 32'h0F00_0000;
      cfg_smm_limit = 32'h0F10_0000;
      cfg_ap_base   = 32'hE000_0000;
      cfg_ap_size   = 3'd2;
      repeat (3) @(negedge clk);
      tests++;
      if (rsp_valid || rsp_dram_en || rsp_snoop || rsp_rd_ones || rsp_cpl != 0 ||
          rsp_addr != 0 || rsp_be != 0) begin
         fails++;
         $display("FAIL R1 reset state: actual v=%b d=%b s=%b o=%b c=%b a=%h b=%h expected all zero",
                  rsp_valid, rsp_dram_en, rsp_snoop, rsp_rd_ones, rsp_cpl, rsp_addr, rsp_be);
      end
      rst_n = 1'b1;
      idle(2);

      // R5 main DRAM, back-to-back (R11)
      send(40'h00_0000_1000, 1'b0, 1'b0, 1'b0, 4'hF, "R5 dram read");
      send(40'h00_0800_0000, 1'b1, 1'b0, 1'b0, 4'h3, "R5 posted write");
      send(40'h00_0800_0004, 1'b1, 1'b0, 1'b1, 4'hC, "R5 write with cpl");
      send(40'h00_0FFF_FFFC, 1'b0, 1'b0, 1'b0, 4'hF, "R5 last below tom");
      send(40'h00_1000_0000, 1'b0, 1'b0, 1'b0, 4'h5, "R9 read at tom");
      idle(1);
      // R6 SMM edges
      send(40'h00_0F00_0040, 1'b0, 1'b0, 1'b0, 4'hF, "R6 R9 smm read");
      send(40'h00_0F0F_FFFC, 1'b1, 1'b0, 1'b1, 4'hF, "R6 R10 smm write cpl");
      send(40'h00_0F10_0000, 1'b0, 1'b0, 1'b0, 4'h1, "R6 smm limit excl");
      send(40'h00_0EFF_FFFC, 1'b1, 1'b0, 1'b0, 4'h8, "R6 below smm base");
      // R10 posted invalid write
      send(40'h00_2000_0000, 1'b1, 1'b0, 1'b0, 4'hF, "R10 posted remap write");
      // R7 aperture
      send(40'h00_E000_0000, 1'b0, 1'b0, 1'b0, 4'hF, "R7 ap base");
      send(40'h00_E0FF_FFFC, 1'b1, 1'b0, 1'b1, 4'hF, "R7 ap top 16MB");
      send(40'h00_E100_0000, 1'b0, 1'b0, 1'b0, 4'h2, "R7 past ap end");
      // R8 VGA
      send(40'h00_000A_0000, 1'b1, 1'b0, 1'b0, 4'hF, "R8 vga write low");
      send(40'h00_000B_FFFF, 1'b0, 1'b0, 1'b0, 4'h8, "R8 vga read high");
      send(40'h00_000A_0000, 1'b0, 1'b0, 1'b0, 4'h1, "R8 vga read low");
      send(40'h00_000C_0000, 1'b0, 1'b0, 1'b0, 4'hF, "R8 above vga");
      send(40'h00_0009_FFFC, 1'b0, 1'b0, 1'b0, 4'hF, "R8 below vga");
      // R3 / R4 above 4 GB
      send(40'h01_0000_0000, 1'b0, 1'b0, 1'b0, 4'hF, "R3 high read");
      send(40'h80_0000_1000, 1'b1, 1'b0, 1'b1, 4'hF, "R4 high write cpl");
      send(40'h01_E000_0000, 1'b1, 1'b0, 1'b0, 4'hF, "R4 high write posted");
      // R2 I/O
      send(40'h00_0000_0CF8, 1'b0, 1'b1, 1'b0, 4'hF, "R2 io read");
      send(40'h00_0000_0080, 1'b1, 1'b1, 1'b1, 4'h1, "R2 io write");
      idle(2);
      // R7 size codes
      cfg_ap_size = 3'd6;
      idle(1);
      send(40'h00_EFFF_FFFC, 1'b0, 1'b0, 1'b0, 4'hF, "R7 ap 256MB top");
      send(40'h00_E100_0000, 1'b1, 1'b0, 1'b1, 4'h4, "R7 ap 256MB mid");
      idle(1);
      cfg_ap_size = 3'd7;
      idle(1);
      send(40'h00_E000_0000, 1'b0, 1'b0, 1'b0, 4'hF, "R7 ap disabled");
      idle(1);
      cfg_ap_size = 3'd0;
      cfg_ap_base = 32'hF040_0000;
      idle(1);
      send(40'h00_F07F_FFFC, 1'b0, 1'b0, 1'b0, 4'hF, "R7 ap 4MB top");
      send(40'h00_F080_0000, 1'b0, 1'b0, 1'b0, 4'hF, "R7 ap 4MB past");
      send(40'h00_F03F_FFFC, 1'b1, 1'b0, 1'b1, 4'hF, "R7 ap 4MB before");
      idle(4);

      tests++;
      if (exp_q.size() != 0) begin
         fails++;
         $display("FAIL R1 outstanding responses: actual %0d expected 0", exp_q.size());
      end
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule